// File: doc/BRIEF.md
# Clock Generator Control Register Bank

This block holds the byte-wide control state of a multi-output clock generator. A two-wire serial slave reaches it through a plain port made of an address, write data, a write strobe and registered read data. The bus protocol engine sits outside this block. Five 8-bit registers drive the output gating logic: per-output enables, free-run and stop-control selections, the VCH frequency select and the spread-spectrum enable.

Some bits cannot be written. Three frequency-select straps are captured while an active-low power-good strobe is low, and they hold once it rises. The CPU stop pin and the multiplier-select pin are shown live. The PCI stop bit behaves in one of two ways, chosen by a mode input. In software mode it is a writable register, and 0 stops the PCI clocks. In hardware mode it ignores writes and reads back the PCI stop pin level, so it shows whether the stop condition is active.

Top module: `clkgen_ctrl_bank`

## Requirements
- R1: A synchronous reset loads the defaults. Byte 0 writable bits: bit 3 = 1, bit 5 = 0, bit 7 = 0. Byte 1 = 0x07 in bits 5..0. Byte 2 = 0x7F. Byte 3 = 0xC7. Byte 4 = 0x3F. The latched straps clear to 0.
- R2: Byte 0 bits 2..0 read the frequency-select straps. They are sampled on every clock edge while `pwr_ok_n` is 0 and held while it is 1.
- R3: Byte 0 bit 4 reads the live CPU stop pin level. Byte 1 bit 7 reads the live multiplier-select pin level.
- R4: Byte 0 bit 5 drives `vch_48` (1 = 48 MHz, 0 = 66 MHz). Byte 0 bit 7 drives `spread_on`. Both bits are writable in either mode.
- R5: In software mode (`sw_mode` = 1), byte 0 bit 3 is writable and reads back as written. `pci_stop_act` is 1 one clock after the bit holds 0.
- R6: In hardware mode, writes to byte 0 bit 3 are ignored and the stored value is kept. The bit reads the PCI stop pin level. `pci_stop_act` is 1 one clock after the pin is low, in either mode.
- R7: Field layout, all writable bits:
  - Byte 1: bits 2..0 drive `cpu_en`; bits 5..3 drive `cpu_free`.
  - Byte 2: bits 6..0 drive `pci_en`.
  - Byte 3: bits 2..0 drive `pcif_en`; bits 5..3 drive `pcif_stopctl`; bit 6 drives `usb_en`; bit 7 drives `dot_en`.
  - Byte 4: bits 5..0 drive `m66_en`.
- R8: Reserved bits read 0 and ignore writes: byte 0 bit 6, byte 1 bit 6, byte 2 bit 7, byte 4 bits 7..6. Writes to the strap and live-pin bits are also ignored.
- R9: Reads from addresses 5 to 7 return 0, and writes to them change no register.
- R10: `rdata` is registered. It shows the addressed byte on the clock edge after the address is presented, and it reflects a write completed on an earlier edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok_n | input | 1 | Active-low strobe: straps valid while 0 |
| fsel_pin | input | 3 | Frequency-select strap pins |
| mult_pin | input | 1 | Current-multiplier select pin level |
| cpu_halt_pin_n | input | 1 | CPU stop pin level (active low) |
| pci_halt_pin_n | input | 1 | PCI stop pin level (active low) |
| sw_mode | input | 1 | 1 = software PCI stop mode, 0 = hardware mode |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rdata | output | 8 | Registered read data |
| fsel | output | 3 | Latched frequency-select straps |
| cpu_en | output | 3 | CPU pair enables |
| cpu_free | output | 3 | CPU pair free-run selects |
| pci_en | output | 7 | PCI output enables |
| pcif_en | output | 3 | Free-running PCI output enables |
| pcif_stopctl | output | 3 | Free-running PCI stop-control selects |
| usb_en | output | 1 | USB clock enable |
| dot_en | output | 1 | DOT clock enable |
| m66_en | output | 6 | 66 MHz-class output enables |
| vch_48 | output | 1 | VCH frequency select |
| spread_on | output | 1 | Spread-spectrum enable |
| pci_stop_act | output | 1 | PCI stop condition active |

## Verification
The hardest case to reach is a write to the PCI stop bit that hardware mode has dropped, because the read path hides it. In hardware mode that bit shows the pin rather than the stored value. The stimulus therefore sets the bit in software mode and switches to hardware mode. It then writes 0, drives the pin both ways and checks the reads against the pin. Finally it returns to software mode with the pin high and reads the bit, which exposes the stored value that should still be 1. Strap holding is reached by moving the strap pins while the strobe is high and reading the old value, then pulsing the strobe low.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned REG_COUNT = 5;
  localparam int unsigned FSEL_W    = 3;

  // Byte 0 bit positions
  localparam int unsigned B0_PCI    = 3;
  localparam int unsigned B0_CPU    = 4;
  localparam int unsigned B0_RSV    = 6;
  localparam int unsigned B0_VCH    = 5;
  localparam int unsigned B0_SPREAD = 7;
  // Byte 1 live multiplier bit
  localparam int unsigned B1_MULT   = 7;

  typedef logic [REG_W-1:0] byte_t;

  // Bits a write may change, mode-independent part
  function automatic byte_t wr_mask(int unsigned idx);
    case (idx)
      0:       wr_mask = 8'hA0;
      1:       wr_mask = 8'h3F;
      2:       wr_mask = 8'h7F;
      3:       wr_mask = 8'hFF;
      4:       wr_mask = 8'h3F;
      default: wr_mask = 8'h00;
    endcase
  endfunction

  function automatic byte_t rst_val(int unsigned idx);
    case (idx)
      0:       rst_val = 8'h08;
      1:       rst_val = 8'h07;
      2:       rst_val = 8'h7F;
      3:       rst_val = 8'hC7;
      4:       rst_val = 8'h3F;
      default: rst_val = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe_n,
  input  logic [W-1:0] pins,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)            q <= '0;
    else if (!strobe_n) q <= pins;
  end

  p_strap_capture_r2: assert property (@(posedge clk) disable iff (rst)
    !strobe_n |=> (q == $past(pins)));
  p_strap_hold_r2: assert property (@(posedge clk) disable iff (rst)
    strobe_n |=> $stable(q));
endmodule

// File: rtl/ctrl_regfile.sv
module ctrl_regfile
  import clkctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [REG_W-1:0]                wdata,
  input  logic                            sw_mode,
  output logic [REG_COUNT-1:0][REG_W-1:0] regs_o
);
  localparam byte_t PCI_MASK = byte_t'(1) << B0_PCI;

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_byte
    localparam byte_t MASK = wr_mask(g);
    localparam byte_t RSTV = rst_val(g);
    byte_t q;
    byte_t eff_mask;

    if (g == 0) begin : g_mode
      always_comb eff_mask = sw_mode ? (MASK | PCI_MASK) : MASK;
    end else begin : g_plain
      always_comb eff_mask = MASK;
    end

    always_ff @(posedge clk) begin
      if (rst)
        q <= RSTV;
      else if (wr_en && (addr == ADDR_W'(g)))
        q <= (q & ~eff_mask) | (wdata & eff_mask);
    end

    assign regs_o[g] = q;
  end

  p_hw_write_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == '0) && !sw_mode) |=> $stable(regs_o[0][B0_PCI]));
  p_reset_defaults_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (regs_o[2] == 8'h7F && regs_o[1] == 8'h07));
  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(4)) |=> (regs_o[4][7:6] == 2'b00));
endmodule

// File: rtl/pci_stop_ctl.sv
module pci_stop_ctl (
  input  logic clk,
  input  logic rst,
  input  logic sw_mode,
  input  logic sw_run_bit,
  input  logic pin_n,
  output logic stop_act
);
  always_ff @(posedge clk) begin
    if (rst) stop_act <= 1'b0;
    else     stop_act <= !pin_n || (sw_mode && !sw_run_bit);
  end

  p_pin_stop_r6: assert property (@(posedge clk) disable iff (rst)
    !pin_n |=> stop_act);
endmodule

// File: rtl/ctrl_readmux.sv
module ctrl_readmux
  import clkctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [REG_COUNT-1:0][REG_W-1:0] regs,
  input  logic [FSEL_W-1:0]               strap,
  input  logic                            cpu_pin_n,
  input  logic                            mult_pin,
  input  logic                            pci_pin_n,
  input  logic                            sw_mode,
  output logic [REG_W-1:0]                rdata
);
  logic [REG_COUNT-1:0][REG_W-1:0] view;
  logic [REG_W-1:0]                rd_next;

  always_comb begin
    view                  = regs;
    view[0][FSEL_W-1:0]   = strap;
    view[0][B0_CPU]       = cpu_pin_n;
    view[0][B0_RSV]       = 1'b0;
    view[0][B0_PCI]       = sw_mode ? regs[0][B0_PCI] : pci_pin_n;
    view[1][B1_MULT]      = mult_pin;
    view[1][6]            = 1'b0;
    view[2][7]            = 1'b0;
    view[4][7:6]          = 2'b00;
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < REG_COUNT; i++)
      if (addr == ADDR_W'(i)) rd_next = view[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  p_oob_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (addr > ADDR_W'(REG_COUNT-1)) |=> (rdata == '0));
  p_live_cpu_pin_r3: assert property (@(posedge clk) disable iff (rst)
    (addr == '0) |=> (rdata[B0_CPU] == $past(cpu_pin_n)));
endmodule

// File: rtl/clkgen_ctrl_bank.sv
module clkgen_ctrl_bank
  import clkctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_ok_n,
  input  logic [FSEL_W-1:0] fsel_pin,
  input  logic              mult_pin,
  input  logic              cpu_halt_pin_n,
  input  logic              pci_halt_pin_n,
  input  logic              sw_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              wr_en,
  output logic [REG_W-1:0]  rdata,
  output logic [FSEL_W-1:0] fsel,
  output logic [2:0]        cpu_en,
  output logic [2:0]        cpu_free,
  output logic [6:0]        pci_en,
  output logic [2:0]        pcif_en,
  output logic [2:0]        pcif_stopctl,
  output logic              usb_en,
  output logic              dot_en,
  output logic [5:0]        m66_en,
  output logic              vch_48,
  output logic              spread_on,
  output logic              pci_stop_act
);
  logic [REG_COUNT-1:0][REG_W-1:0] regs;

  strap_capture #(.W(FSEL_W)) u_strap (
    .clk(clk), .rst(rst), .strobe_n(pwr_ok_n), .pins(fsel_pin), .q(fsel)
  );

  ctrl_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .sw_mode(sw_mode), .regs_o(regs)
  );

  pci_stop_ctl u_stop (
    .clk(clk), .rst(rst), .sw_mode(sw_mode), .sw_run_bit(regs[0][B0_PCI]),
    .pin_n(pci_halt_pin_n), .stop_act(pci_stop_act)
  );

  ctrl_readmux #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .addr(addr), .regs(regs), .strap(fsel),
    .cpu_pin_n(cpu_halt_pin_n), .mult_pin(mult_pin),
    .pci_pin_n(pci_halt_pin_n), .sw_mode(sw_mode), .rdata(rdata)
  );

  assign vch_48       = regs[0][B0_VCH];
  assign spread_on    = regs[0][B0_SPREAD];
  assign cpu_en       = regs[1][2:0];
  assign cpu_free     = regs[1][5:3];
  assign pci_en       = regs[2][6:0];
  assign pcif_en      = regs[3][2:0];
  assign pcif_stopctl = regs[3][5:3];
  assign usb_en       = regs[3][6];
  assign dot_en       = regs[3][7];
  assign m66_en       = regs[4][5:0];
endmodule

// File: tb/clkgen_ctrl_bank_test.sv
module clkgen_ctrl_bank_test;
  localparam time PERIOD = 10ns;

  typedef struct packed {
    logic [2:0] a;
    logic [7:0] d;
    logic [7:0] e;
  } vec_t;

  // Write d to a, then read a and expect e
  // (cpu pin = 1, mult pin = 0, straps = 010, software mode)
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 8'hFF, 8'hBA}, '{3'd0, 8'h00, 8'h12},
    '{3'd1, 8'hFF, 8'h3F}, '{3'd1, 8'h2A, 8'h2A},
    '{3'd2, 8'hFF, 8'h7F}, '{3'd2, 8'h55, 8'h55},
    '{3'd3, 8'hFF, 8'hFF}, '{3'd3, 8'h5A, 8'h5A},
    '{3'd4, 8'hFF, 8'h3F}, '{3'd4, 8'h12, 8'h12},
    '{3'd5, 8'hFF, 8'h00}, '{3'd7, 8'h33, 8'h00}
  };

  logic clk = 0, rst = 1, pwr_ok_n = 0, mult_pin = 0;
  logic cpu_halt_pin_n = 1, pci_halt_pin_n = 1, sw_mode = 1, wr_en = 0;
  logic [2:0] fsel_pin = 3'b101, addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [2:0] fsel, cpu_en, cpu_free, pcif_en, pcif_stopctl;
  logic [6:0] pci_en;
  logic [5:0] m66_en;
  logic usb_en, dot_en, vch_48, spread_on, pci_stop_act;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  clkgen_ctrl_bank uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic do_read(input logic [2:0] a);
    @(negedge clk); addr = a; wr_en = 0;
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD*100000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);          // strobe low: straps 101 captured
    pwr_ok_n = 1;
    // R1 reset defaults on outputs and readback
    chk("R1 cpu_en", cpu_en, 3'h7);   chk("R1 cpu_free", cpu_free, 0);
    chk("R1 pci_en", pci_en, 7'h7F);  chk("R1 pcif_en", pcif_en, 3'h7);
    chk("R1 pcif_stopctl", pcif_stopctl, 0);
    chk("R1 usb/dot", {usb_en, dot_en}, 2'b11);
    chk("R1 m66_en", m66_en, 6'h3F);
    chk("R1 vch/spread", {vch_48, spread_on}, 0);
    chk("R1 pci_stop_act", pci_stop_act, 0);
    do_read(0); chk("R1 byte0", rdata, 8'h1D);
    do_read(3); chk("R1 byte3", rdata, 8'hC7);
    // R2 strap hold and capture
    fsel_pin = 3'b010;
    do_read(0); chk("R2 strap hold", rdata[2:0], 3'b101);
    @(negedge clk); pwr_ok_n = 0; @(negedge clk); pwr_ok_n = 1;
    do_read(0); chk("R2 strap capture", rdata[2:0], 3'b010);
    chk("R2 fsel out", fsel, 3'b010);
    // R3 live pins
    cpu_halt_pin_n = 0; mult_pin = 1;
    do_read(0); chk("R3 cpu pin bit", rdata[4], 0);
    do_read(1); chk("R3 mult pin bit", rdata[7], 1);
    cpu_halt_pin_n = 1; mult_pin = 0;
    // Table: R4 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      do_write(VECS[i].a, VECS[i].d);
      do_read(VECS[i].a);
      chk($sformatf("R8 R9 R10 vector %0d", i), rdata, VECS[i].e);
    end
    do_read(3); chk("R9 high writes no effect", rdata, 8'h5A);
    chk("R7 cpu_en", cpu_en, 3'b010);   chk("R7 cpu_free", cpu_free, 3'b101);
    chk("R7 pci_en", pci_en, 7'h55);    chk("R7 pcif_en", pcif_en, 3'b010);
    chk("R7 pcif_stopctl", pcif_stopctl, 3'b011);
    chk("R7 usb/dot", {usb_en, dot_en}, 2'b10);
    chk("R7 m66_en", m66_en, 6'h12);
    chk("R5 sw stop from bit 0", pci_stop_act, 1);
    // R4 R5 software mode
    do_write(0, 8'h28);
    chk("R4 vch_48", vch_48, 1);
    @(negedge clk);
    chk("R5 sw run bit 1", pci_stop_act, 0);
    // R6 hardware mode
    sw_mode = 0;
    do_write(0, 8'h80);
    chk("R4 spread_on", spread_on, 1);
    do_read(0); chk("R6 bit reads pin high", rdata[3], 1);
    chk("R6 no stop pin high", pci_stop_act, 0);
    pci_halt_pin_n = 0;
    do_read(0); chk("R6 bit reads pin low", rdata[3], 0);
    chk("R6 stop from pin", pci_stop_act, 1);
    pci_halt_pin_n = 1; sw_mode = 1;
    do_read(0); chk("R6 hw write ignored", rdata[3], 1);
    chk("R6 stop released", pci_stop_act, 0);
    // R1 reset mid-run
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    do_read(1); chk("R1 reset reload byte1", rdata, 8'h07);
    chk("R1 reset fsel cleared", fsel, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule